// File: doc/BRIEF.md
# Conditioned-Operand Arithmetic Logic Unit

This block is a purely combinational 16-bit arithmetic logic unit. Its only arithmetic core produces either the sum or the bitwise AND of two operands. Around that core sit small conditioning stages. Each operand can be forced to zero and then bit-inverted. The core output can be bit-inverted once more before it leaves the block. With these stages, six control bits yield eighteen useful functions, including constants, pass-through, complement, two's-complement negation, increment, decrement, add, subtract, AND and OR. No per-operation decoder is involved.

A datapath drives two operands and a 6-bit control word, and reads the result in the same cycle. Two status bits come with the result. One reports an all-zero result. The other copies the sign bit of the result. There is no carry-out or overflow output.

Top module: `cond_alu16`

## Requirements
- R1: When ctrl[5] (zero-x) is 1, the x operand is replaced by 0 before its inversion stage. With ctrl = 6'b100010 the result equals y.
- R2: When ctrl[4] (invert-x) is 1, the x operand is bitwise complemented after the zeroing stage. With ctrl = 6'b110010 the result equals y - 1.
- R3: ctrl[3] (zero-y) and ctrl[2] (invert-y) act on y in the same order. With ctrl = 6'b001000 the result is 0. With ctrl = 6'b001110 the result is x - 1.
- R4: When ctrl[1] is 1, the core adds the conditioned operands modulo 2^16 and drops the carry. For example, 16'hFFFF + 16'h0001 gives 16'h0000.
- R5: When ctrl[1] is 0, the core forms the bitwise AND of the conditioned operands.
- R6: When ctrl[0] (invert-out) is 1, the core output is bitwise complemented to form the result.
- R7: zero_flag is 1 exactly when the result is 16'h0000.
- R8: neg_flag equals bit 15 of the result.
- R9: The 18 control codes (zx nx zy ny f no, MSB first) give these functions. 101010 gives 0, 111111 gives 1, and 111010 gives -1. 001100 gives x and 110000 gives y. 001101 gives ~x and 110001 gives ~y. 001111 gives -x and 110011 gives -y. 011111 gives x+1 and 110111 gives y+1. 001110 gives x-1 and 110010 gives y-1. 000010 gives x+y, 010011 gives x-y, and 000111 gives y-x. 000000 gives x&y and 010101 gives x|y.
- R10: The outputs follow the inputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_in | input | 16 | First operand |
| y_in | input | 16 | Second operand |
| ctrl | input | 6 | {zx, nx, zy, ny, f, no}, MSB first |
| result | output | 16 | Final conditioned result |
| zero_flag | output | 1 | 1 when result is zero |
| neg_flag | output | 1 | Copy of result bit 15 |

## Verification
Carry wrap-around and the zero flag can both come from one addition. The bench provokes this by adding 16'hFFFF and 16'h0001, then judges that the result is 0, zero_flag is 1 and neg_flag is 0. The bench also checks that inversion of an operand and inversion of the output combine correctly in a single evaluation. It does this by running x-y and y-x on random and extreme operands, including 16'h8000 and 16'h7FFF, and comparing against two's-complement subtraction.

// File: rtl/cond_alu_pkg.sv
package cond_alu_pkg;
  localparam int ALU_W = 16;
  localparam int CTRL_W = 6;

  // Bit order matters: MSB is zero-x, LSB is invert-out
  typedef struct packed {
    logic zx;
    logic nx;
    logic zy;
    logic ny;
    logic f;
    logic no;
  } alu_ctrl_t;

  typedef enum int {
    ADDER_BEHAV = 0,
    ADDER_RIPPLE = 1
  } adder_kind_e;
endpackage

// File: rtl/operand_cond.sv
module operand_cond #(
  parameter int W = cond_alu_pkg::ALU_W
) (
  input  logic [W-1:0] din,
  input  logic         zero_en,
  input  logic         inv_en,
  output logic [W-1:0] dout
);
  // zeroing happens first, inversion second
  function automatic logic [W-1:0] condition(input logic [W-1:0] v,
                                             input logic z, input logic n);
    logic [W-1:0] t;
    t = z ? '0 : v;
    return n ? ~t : t;
  endfunction

  always_comb begin
    dout = condition(din, zero_en, inv_en);
    if (zero_en && !inv_en)
      AST_ZERO_FORCED: assert (dout == '0);           // R1
    if (zero_en && inv_en)
      AST_ZERO_THEN_INV: assert (dout == '1);         // R2
    if (!zero_en && !inv_en)
      AST_PASS_THROUGH: assert (dout == din);         // R3
  end
endmodule

// File: rtl/alu_core.sv
module alu_core #(
  parameter int W = cond_alu_pkg::ALU_W,
  parameter int ADDER_KIND = cond_alu_pkg::ADDER_RIPPLE
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sel_add,
  output logic [W-1:0] core_out
);
  logic [W-1:0] sum_w;

  generate
    if (ADDER_KIND == cond_alu_pkg::ADDER_RIPPLE) begin : g_ripple
      logic [W-1:0] carry;
      assign carry[0] = 1'b0;
      for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum_w[i] = a[i] ^ b[i] ^ carry[i];
        if (i < W - 1) begin : g_carry
          assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
        end
      end
    end else begin : g_behav
      assign sum_w = a + b;  // modulo 2^W, carry out dropped
    end
  endgenerate

  always_comb begin
    core_out = sel_add ? sum_w : (a & b);
    if (!sel_add)
      AST_AND_SUBSET: assert (((core_out & ~a) == '0) && ((core_out & ~b) == '0)); // R5
    if (sel_add && (b == '0))
      AST_ADD_IDENTITY: assert (core_out == a);       // R4
    if (sel_add && (a == '1) && (b == {{(W-1){1'b0}}, 1'b1}))
      AST_ADD_WRAP: assert (core_out == '0);          // R4
  end
endmodule

// File: rtl/result_stage.sv
module result_stage #(
  parameter int W = cond_alu_pkg::ALU_W
) (
  input  logic [W-1:0] core_in,
  input  logic         inv_out,
  output logic [W-1:0] result,
  output logic         zero_flag,
  output logic         neg_flag
);
  always_comb begin
    result    = inv_out ? ~core_in : core_in;
    zero_flag = ~|result;
    neg_flag  = result[W-1];
    AST_POST_INV: assert ((result ^ core_in) == (inv_out ? '1 : '0)); // R6
    AST_FLAGS_EXCL: assert (!(zero_flag && neg_flag));               // R7
  end
endmodule

// File: rtl/cond_alu16.sv
module cond_alu16 #(
  parameter int W = cond_alu_pkg::ALU_W,
  parameter int ADDER_KIND = cond_alu_pkg::ADDER_RIPPLE
) (
  input  logic [W-1:0]                    x_in,
  input  logic [W-1:0]                    y_in,
  input  logic [cond_alu_pkg::CTRL_W-1:0] ctrl,
  output logic [W-1:0]                    result,
  output logic                            zero_flag,
  output logic                            neg_flag
);
  cond_alu_pkg::alu_ctrl_t c;
  logic [W-1:0] x_cond;
  logic [W-1:0] y_cond;
  logic [W-1:0] core_val;

  assign c = cond_alu_pkg::alu_ctrl_t'(ctrl);

  operand_cond #(.W(W)) u_xcond (
    .din(x_in), .zero_en(c.zx), .inv_en(c.nx), .dout(x_cond)
  );

  operand_cond #(.W(W)) u_ycond (
    .din(y_in), .zero_en(c.zy), .inv_en(c.ny), .dout(y_cond)
  );

  alu_core #(.W(W), .ADDER_KIND(ADDER_KIND)) u_core (
    .a(x_cond), .b(y_cond), .sel_add(c.f), .core_out(core_val)
  );

  result_stage #(.W(W)) u_post (
    .core_in(core_val), .inv_out(c.no),
    .result(result), .zero_flag(zero_flag), .neg_flag(neg_flag)
  );

  always_comb begin
    if (ctrl == 6'b101010)
      AST_CONST_ZERO: assert (result == '0 && zero_flag); // R9
    if (ctrl == 6'b110000)
      AST_PASS_Y: assert (result == y_in);                // R9
  end
endmodule

// File: tb/cond_alu16_bench.sv
module cond_alu16_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0] x_in, y_in, result;
  logic [5:0]  ctrl;
  logic        zero_flag, neg_flag;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  cond_alu16 u_cond_alu16 (
    .x_in(x_in), .y_in(y_in), .ctrl(ctrl),
    .result(result), .zero_flag(zero_flag), .neg_flag(neg_flag)
  );

  // code table: index i selects the function expected by ref_fn
  localparam logic [5:0] CODES [18] = '{
    6'b101010, 6'b111111, 6'b111010, 6'b001100, 6'b110000, 6'b001101,
    6'b110001, 6'b001111, 6'b110011, 6'b011111, 6'b110111, 6'b001110,
    6'b110010, 6'b000010, 6'b010011, 6'b000111, 6'b000000, 6'b010101
  };

  function automatic logic [15:0] ref_fn(int idx, logic [15:0] x, logic [15:0] y);
    case (idx)
      0: return 16'd0;
      1: return 16'd1;
      2: return 16'hFFFF;
      3: return x;
      4: return y;
      5: return ~x;
      6: return ~y;
      7: return 16'd0 - x;
      8: return 16'd0 - y;
      9: return x + 16'd1;
      10: return y + 16'd1;
      11: return x - 16'd1;
      12: return y - 16'd1;
      13: return x + y;
      14: return x - y;
      15: return y - x;
      16: return x & y;
      default: return x | y;
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (x=%h y=%h ctrl=%b)",
               tag, got, exp, x_in, y_in, ctrl);
    end
  endtask

  task automatic apply(logic [5:0] c, logic [15:0] x, logic [15:0] y);
    @(negedge clk);
    ctrl = c; x_in = x; y_in = y;
    #1;
  endtask

  task automatic check_flags(logic [15:0] exp);
    check("R7 zero_flag", {15'd0, zero_flag}, {15'd0, exp == 16'd0});
    check("R8 neg_flag",  {15'd0, neg_flag},  {15'd0, exp[15]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] ex;
    ctrl = 6'b101010; x_in = 16'h1234; y_in = 16'h5678;
    // initial state: constant-zero code
    #1;
    check("R9 initial result", result, 16'd0);
    check("R7 initial zero_flag", {15'd0, zero_flag}, 16'd1);

    // R9: table walk, corner and random operands
    for (int k = 0; k < 40; k++) begin
      logic [15:0] xv, yv;
      case (k)
        0: begin xv = 16'h0000; yv = 16'h0000; end
        1: begin xv = 16'hFFFF; yv = 16'h0001; end
        2: begin xv = 16'h8000; yv = 16'h7FFF; end
        3: begin xv = 16'h7FFF; yv = 16'h8000; end
        default: begin xv = 16'($urandom); yv = 16'($urandom); end
      endcase
      for (int i = 0; i < 18; i++) begin
        apply(CODES[i], xv, yv);
        ex = ref_fn(i, xv, yv);
        check("R9 function", result, ex);
        check_flags(ex);
      end
    end

    // R1: zero-x, add -> y
    apply(6'b100010, 16'hABCD, 16'h1357);
    check("R1 zero-x add", result, 16'h1357);
    // R2: zero then invert x, add -> y-1
    apply(6'b110010, 16'hABCD, 16'h1357);
    check("R2 zero-invert-x", result, 16'h1356);
    // R3: zero-y with AND -> 0; invert zeroed y, add -> x-1
    apply(6'b001000, 16'hFFFF, 16'hFFFF);
    check("R3 zero-y and", result, 16'h0000);
    apply(6'b001110, 16'h0000, 16'h4444);
    check("R3 zero-invert-y", result, 16'hFFFF);
    // R4: wrap-around with zero flag
    apply(6'b000010, 16'hFFFF, 16'h0001);
    check("R4 add wrap", result, 16'h0000);
    check("R7 zero after wrap", {15'd0, zero_flag}, 16'd1);
    check("R8 neg after wrap", {15'd0, neg_flag}, 16'd0);
    apply(6'b000010, 16'h8000, 16'h8000);
    check("R4 add wrap msb", result, 16'h0000);
    // R5: AND
    apply(6'b000000, 16'hF0F0, 16'h3C3C);
    check("R5 and", result, 16'h3030);
    // R6: invert-out on AND
    apply(6'b000001, 16'hF0F0, 16'h3C3C);
    check("R6 nand", result, 16'hCFCF);
    // R8: sign bit
    apply(6'b001100, 16'h8001, 16'h0000);
    check("R8 neg_flag set", {15'd0, neg_flag}, 16'd1);
    check("R7 zero_flag clear", {15'd0, zero_flag}, 16'd0);
    // R10: outputs follow inputs with no clock edge
    @(posedge clk); #0.5;
    ctrl = 6'b000010; x_in = 16'd100; y_in = 16'd23;
    #0.5;
    check("R10 no-clock update", result, 16'd123);
    x_in = 16'd1;
    #0.5;
    check("R10 second update", result, 16'd24);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule